// File: doc/BRIEF.md
# Single-Cycle Load/Store Arithmetic Core

This block is a small 32-bit processor that completes one instruction per clock. In that clock it fetches the word at the program counter, decodes it, reads two source registers, computes a result and commits it. The core supports four instructions: register add, register subtract, word load and word store. Every other encoding is a no-op. The program counter, a 32-entry register file, an adder/subtractor, the decoder and two small word memories all sit inside the block. One memory holds instructions and the other holds data.

While `run` is low the core is paused. A testbench or a boot agent then fills either memory through a load port. While `run` is high the core executes one instruction on each rising edge. Each register write-back and each memory store appears on commit ports in the cycle before the edge that performs it. Two debug read ports return any register and any data word without disturbing execution. A sticky flag records any word access whose effective address is not a multiple of four.

Top module: `rcore_top`

## Requirements
- R1: After reset the program counter is 0, the error flag is 0 and every register reads 0.
- R2: On each rising edge with `run` high the program counter advances by 4. With `run` low it holds its value.
- R3: Opcode 0 with function code 32 (bits 5:0) writes `reg[rs] + reg[rt]` into `reg[rd]`, modulo 2^32. The fields are rs = bits 25:21, rt = 20:16 and rd = 15:11.
- R4: Opcode 0 with function code 34 writes `reg[rs] - reg[rt]` into `reg[rd]`, modulo 2^32.
- R5: Opcode 35 (bits 31:26) loads into `reg[rt]` the data word at byte address `reg[rs] + sext(imm16)`. The immediate is bits 15:0. The word index is byte address bits 2 and up, taken modulo the memory depth.
- R6: Opcode 43 stores `reg[rt]` to the data word at byte address `reg[rs] + sext(imm16)`.
- R7: The 16-bit offset is sign-extended, so a negative offset reaches addresses below the base register.
- R8: Register 0 always reads as zero, and a write aimed at it is discarded. No commit event is shown for such a write.
- R9: A load or store whose effective address has bits 1:0 other than 00 sets the error flag. The flag stays set until reset. The access changes no register and no memory word.
- R10: Any opcode other than 0, 35 and 43, and any opcode-0 function code other than 32 and 34, changes no register and no memory word.
- R11: An instruction reads the value that the immediately preceding instruction wrote to a register.
- R12: The load port writes instruction memory (`loadSel` = 0) or data memory (`loadSel` = 1) only while `run` is low. While `run` is high the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per edge when high |
| loadEn | input | 1 | Load-port write strobe |
| loadSel | input | 1 | 0 selects instruction memory, 1 selects data memory |
| loadAddr | input | LAW | Word index for the load port |
| loadData | input | 32 | Word to write through the load port |
| dbgRegSel | input | 5 | Register number for the debug read |
| dbgRegData | output | 32 | Value of the selected register |
| dbgMemSel | input | LAW | Data-memory word index for the debug read |
| dbgMemData | output | 32 | Value of the selected data word |
| pc | output | 32 | Program counter |
| regWen | output | 1 | A register write commits at the next edge |
| regWaddr | output | 5 | Destination register of that write |
| regWdata | output | 32 | Value being written |
| memWen | output | 1 | A data store commits at the next edge |
| memWaddr | output | 32 | Byte address of that store |
| memWdata | output | 32 | Word being stored |
| errFlag | output | 1 | Sticky misaligned-access flag |

## Verification
A wrong ALU operation, a bad decode or a wrong operand path shows up in the same cycle as a commit event with the wrong address or data. A missing or extra commit event shows as a mismatch against the ordered stream of expected events. Corrupted register or memory state that no later instruction consumes stays hidden until the debug ports are swept once `run` drops. The program reads results back soon after writing them, so such corruption reaches the commit ports within one or two instructions. A program counter that drifts is visible on `pc` every cycle, and through the fetched instruction stream immediately after that.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  // Strobes from decode to datapath
  typedef struct packed {
    logic regWrite;
    logic destIsRd;
    logic memRead;
    logic memWrite;
    logic aluSub;
    logic useImm;
  } ctrl_t;
endpackage

// File: rtl/rcore_control.sv
module rcore_control
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      strobes
);
  always_comb begin
    strobes = '0;
    unique case (opcode)
      OP_REG: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          strobes.regWrite = 1'b1;
          strobes.destIsRd = 1'b1;
          strobes.aluSub   = (funct == FN_SUB);
        end
      end
      OP_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.memRead  = 1'b1;
        strobes.useImm   = 1'b1;
      end
      OP_STORE: begin
        strobes.memWrite = 1'b1;
        strobes.useImm   = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int N  = 32,
  parameter int W  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [AW-1:0] addrC,
  output logic [W-1:0]  dataA,
  output logic [W-1:0]  dataB,
  output logic [W-1:0]  dataC,
  input  logic          wEn,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wEn && wAddr != '0) begin
      regs[wAddr] <= wData;
    end
  end

  assign dataA = (addrA == '0) ? '0 : regs[addrA];
  assign dataB = (addrB == '0) ? '0 : regs[addrB];
  assign dataC = (addrC == '0) ? '0 : regs[addrC];
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         doSub,
  output logic [W-1:0] result
);
  assign result = doSub ? (opA - opB) : (opA + opB);
endmodule

// File: rtl/rcore_datapath.sv
module rcore_datapath
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  ctrl_t           strobes,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  input  logic            loadEn,
  input  logic            loadSel,
  input  logic [LAW-1:0]  loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  logic [RAW-1:0]  dbgRegSel,
  output logic [XLEN-1:0] dbgRegData,
  input  logic [LAW-1:0]  dbgMemSel,
  output logic [XLEN-1:0] dbgMemData,
  output logic [XLEN-1:0] pc,
  output logic            regWen,
  output logic [RAW-1:0]  regWaddr,
  output logic [XLEN-1:0] regWdata,
  output logic            memWen,
  output logic [XLEN-1:0] memWaddr,
  output logic [XLEN-1:0] memWdata,
  output logic            errFlag
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] instr;
  logic [RAW-1:0]  rsSel, rtSel, rdSel;
  logic [15:0]     imm16;
  logic [XLEN-1:0] immExt, rsVal, rtVal, aluB, aluY;
  logic [DAW-1:0]  dIdx;
  logic            memAccess, misaligned;
  logic            loadWindow;

  assign instr  = imem[pc[2 +: IAW]];
  assign opcode = instr[31:26];
  assign rsSel  = instr[25:21];
  assign rtSel  = instr[20:16];
  assign rdSel  = instr[15:11];
  assign funct  = instr[5:0];
  assign imm16  = instr[15:0];
  assign immExt = {{(XLEN-16){imm16[15]}}, imm16};

  rcore_regfile #(.N(NREG), .W(XLEN)) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .addrA (rsSel),
    .addrB (rtSel),
    .addrC (dbgRegSel),
    .dataA (rsVal),
    .dataB (rtVal),
    .dataC (dbgRegData),
    .wEn   (regWen),
    .wAddr (regWaddr),
    .wData (regWdata)
  );

  assign aluB = strobes.useImm ? immExt : rtVal;

  rcore_alu #(.W(XLEN)) u_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .doSub  (strobes.aluSub),
    .result (aluY)
  );

  assign memAccess  = strobes.memRead | strobes.memWrite;
  assign misaligned = memAccess && (aluY[1:0] != 2'b00);
  assign dIdx       = aluY[2 +: DAW];

  assign regWaddr = strobes.destIsRd ? rdSel : rtSel;
  assign regWdata = strobes.memRead ? dmem[dIdx] : aluY;
  assign regWen   = run && strobes.regWrite && !misaligned && (regWaddr != '0);

  assign memWen   = run && strobes.memWrite && !misaligned;
  assign memWaddr = aluY;
  assign memWdata = rtVal;

  assign loadWindow = loadEn && !run;
  assign dbgMemData = dmem[dbgMemSel[DAW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else if (run) begin
      pc <= pc + XLEN'(4);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (run && misaligned) begin
      errFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (memWen) begin
      dmem[dIdx] <= memWdata;
    end else if (loadWindow && loadSel) begin
      dmem[loadAddr[DAW-1:0]] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (loadWindow && !loadSel) begin
      imem[loadAddr[IAW-1:0]] <= loadData;
    end
  end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            loadEn,
  input  logic            loadSel,
  input  logic [LAW-1:0]  loadAddr,
  input  logic [31:0]     loadData,
  input  logic [4:0]      dbgRegSel,
  output logic [31:0]     dbgRegData,
  input  logic [LAW-1:0]  dbgMemSel,
  output logic [31:0]     dbgMemData,
  output logic [31:0]     pc,
  output logic            regWen,
  output logic [4:0]      regWaddr,
  output logic [31:0]     regWdata,
  output logic            memWen,
  output logic [31:0]     memWaddr,
  output logic [31:0]     memWdata,
  output logic            errFlag
);
  ctrl_t      strobes;
  logic [5:0] opcode;
  logic [5:0] funct;

  rcore_control u_ctrl (
    .opcode  (opcode),
    .funct   (funct),
    .strobes (strobes)
  );

  rcore_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .strobes    (strobes),
    .opcode     (opcode),
    .funct      (funct),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .dbgMemSel  (dbgMemSel),
    .dbgMemData (dbgMemData),
    .pc         (pc),
    .regWen     (regWen),
    .regWaddr   (regWaddr),
    .regWdata   (regWdata),
    .memWen     (memWen),
    .memWaddr   (memWaddr),
    .memWdata   (memWdata),
    .errFlag    (errFlag)
  );
endmodule

// File: rtl/rcore_checker.sv
module rcore_checker (
  input logic        clk,
  input logic        rstN,
  input logic        run,
  input logic [31:0] pc,
  input logic        regWen,
  input logic [4:0]  regWaddr,
  input logic        memWen,
  input logic [31:0] memWaddr,
  input logic        errFlag
);
  // R2: the counter steps by one word per executed instruction
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    run |=> pc == $past(pc) + 32'd4);

  // R2: the counter holds while paused
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(pc));

  // R8: no commit event ever targets register 0
  p_no_zero_dest_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWen |-> regWaddr != 5'd0);

  // R9: the flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9: the access that raises the flag commits nothing
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(!regWen && !memWen));

  // R6: stores only ever reach word-aligned addresses
  p_store_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWen |-> memWaddr[1:0] == 2'b00);

  // R12: a paused core commits nothing
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !regWen && !memWen);
endmodule

bind rcore_top rcore_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .run      (run),
  .pc       (pc),
  .regWen   (regWen),
  .regWaddr (regWaddr),
  .memWen   (memWen),
  .memWaddr (memWaddr),
  .errFlag  (errFlag)
);

// File: tb/test_rcore_top.sv
`timescale 1ns/1ps
module test_rcore_top;
  localparam int LAW = 6;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [LAW-1:0] loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegData;
  logic [LAW-1:0] dbgMemSel = '0;
  logic [31:0] dbgMemData;
  logic [31:0] pc;
  logic        regWen;
  logic [4:0]  regWaddr;
  logic [31:0] regWdata;
  logic        memWen;
  logic [31:0] memWaddr;
  logic [31:0] memWdata;
  logic        errFlag;

  always #4 clk = ~clk;

  rcore_top i_rcore_top (
    .clk(clk), .rstN(rstN), .run(run),
    .loadEn(loadEn), .loadSel(loadSel), .loadAddr(loadAddr), .loadData(loadData),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemSel(dbgMemSel), .dbgMemData(dbgMemData),
    .pc(pc), .regWen(regWen), .regWaddr(regWaddr), .regWdata(regWdata),
    .memWen(memWen), .memWaddr(memWaddr), .memWdata(memWdata), .errFlag(errFlag)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state
  logic [31:0] refReg [32];
  logic [31:0] refMem [WORDS];
  logic [31:0] refImem [WORDS];
  logic [31:0] refPc;
  logic        refErr;

  // Scoreboard: {kind(1=mem), addr, data}
  logic [64:0] expQ [$];
  string       tagQ [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rIns(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] iIns(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  // Independent model of one instruction; pushes expected commit events
  task automatic refStep();
    logic [31:0] ins, ea, val;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    ins = refImem[refPc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    ea = refReg[rs] + {{16{ins[15]}}, ins[15:0]};
    if (op == 6'd0 && (fn == 6'd32 || fn == 6'd34)) begin
      val = (fn == 6'd32) ? refReg[rs] + refReg[rt] : refReg[rs] - refReg[rt];
      if (rd != 5'd0) begin
        refReg[rd] = val;
        expQ.push_back({1'b0, 27'd0, rd, val});
        tagQ.push_back((fn == 6'd32) ? "R3 add" : "R4 sub");
      end
    end else if (op == 6'd35) begin
      if (ea[1:0] != 2'b00) refErr = 1'b1;
      else if (rt != 5'd0) begin
        refReg[rt] = refMem[ea[7:2]];
        expQ.push_back({1'b0, 27'd0, rt, refMem[ea[7:2]]});
        tagQ.push_back("R5 load");
      end
    end else if (op == 6'd43) begin
      if (ea[1:0] != 2'b00) refErr = 1'b1;
      else begin
        refMem[ea[7:2]] = refReg[rt];
        expQ.push_back({1'b1, ea, refReg[rt]});
        tagQ.push_back("R6 store");
      end
    end
    refPc = refPc + 32'd4;
  endtask

  task automatic loadWord(logic sel, int addr, logic [31:0] data);
    loadEn = 1'b1; loadSel = sel; loadAddr = LAW'(addr); loadData = data;
    @(posedge clk); #1;
    loadEn = 1'b0;
  endtask

  task automatic runSteps(int n);
    for (int k = 0; k < n; k++) refStep();
    run = 1'b1;
    repeat (n) @(posedge clk);
    #1 run = 1'b0;
  endtask

  // Monitor: compare every commit event against the scoreboard
  always @(negedge clk) begin
    if (rstN && (regWen || memWen)) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected commit actual=%h expected=none",
                 memWen ? memWaddr : {27'd0, regWaddr});
      end else begin
        logic [64:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " kind"}, {31'd0, memWen}, {31'd0, e[64]});
        chk({t, " addr"}, memWen ? memWaddr : {27'd0, regWaddr}, e[63:32]);
        chk({t, " data"}, memWen ? memWdata : regWdata, e[31:0]);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    logic [31:0] prog [$];
    logic [31:0] held;
    for (int i = 0; i < 32; i++) refReg[i] = '0;
    refPc = '0; refErr = 1'b0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 pc", pc, 32'd0);
    chk("R1 err", {31'd0, errFlag}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      dbgRegSel = 5'(i); #1;
      chk($sformatf("R1 reg%0d", i), dbgRegData, 32'd0);
    end

    // Data memory image
    for (int i = 0; i < WORDS; i++) refMem[i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    refMem[0] = 32'h0000_0011;
    refMem[1] = 32'h7FFF_FFFF;
    refMem[63] = 32'hCAFE_0063;

    // Program
    prog.push_back(iIns(35, 0, 1, 16'd0));       // R5 lw r1,0(r0)
    prog.push_back(iIns(35, 0, 2, 16'd4));       // R5 lw r2,4(r0)
    prog.push_back(rIns(1, 2, 3, 32));           // R3/R11 add r3 overflows
    prog.push_back(rIns(1, 2, 4, 34));           // R4 sub negative result
    prog.push_back(iIns(43, 0, 3, 16'd8));       // R6 sw r3,8(r0)
    prog.push_back(rIns(3, 3, 5, 32));           // R11 uses fresh r3
    prog.push_back(iIns(35, 7, 6, 16'hFFFC));    // R7 lw r6,-4(r7) wraps
    prog.push_back(rIns(1, 2, 0, 32));           // R8 write to r0 dropped
    prog.push_back(iIns(8, 1, 9, 16'h0005));     // R10 unsupported opcode
    prog.push_back(rIns(1, 2, 9, 33));           // R10 unsupported funct
    prog.push_back(rIns(0, 1, 8, 32));           // R8 r0 reads zero
    prog.push_back(iIns(35, 0, 9, 16'd2));       // R9 misaligned load
    prog.push_back(iIns(43, 0, 1, 16'd1));       // R9 misaligned store
    prog.push_back(iIns(43, 1, 4, 16'hFFFF));    // R7 sw r4,-1(r1) -> addr 0x10
    prog.push_back(iIns(35, 6, 10, 16'd0));      // R9 misaligned via base
    prog.push_back(rIns(9, 1, 10, 32));          // R9 r9 untouched
    prog.push_back(iIns(35, 0, 11, 16'd16));     // R6 read back stored word
    for (int i = 0; i < WORDS; i++) refImem[i] = (i < prog.size()) ? prog[i] : 32'd0;

    // R12: load both memories while paused
    @(posedge clk); #1;
    for (int i = 0; i < WORDS; i++) loadWord(1'b1, i, refMem[i]);
    for (int i = 0; i < WORDS; i++) loadWord(1'b0, i, refImem[i]);
    @(negedge clk);
    dbgMemSel = 6'd63; #1;
    chk("R12 dmem loaded", dbgMemData, 32'hCAFE_0063);
    chk("R2 pc idle during load", pc, 32'd0);

    // First segment
    @(posedge clk); #1;
    runSteps(11);
    @(negedge clk);
    chk("R2 pc after run", pc, refPc);
    chk("R9 err clear so far", {31'd0, errFlag}, 32'd0);
    dbgRegSel = 5'd0; #1;
    chk("R8 reg0 zero", dbgRegData, 32'd0);

    // R2: hold while paused
    held = pc;
    repeat (3) @(negedge clk);
    chk("R2 pc holds", pc, held);

    // Second segment, load port driven during run (R12 ignored)
    @(posedge clk); #1;
    loadEn = 1'b1; loadSel = 1'b1; loadAddr = 6'd20; loadData = 32'hDEAD_BEEF;
    runSteps(6);
    loadEn = 1'b0;
    @(negedge clk);
    chk("R2 pc after second run", pc, refPc);
    chk("R9 err set", {31'd0, errFlag}, {31'd0, refErr});
    dbgMemSel = 6'd20; #1;
    chk("R12 load ignored during run", dbgMemData, refMem[20]);

    // R9 sticky across idle cycles
    repeat (4) @(negedge clk);
    chk("R9 err sticky", {31'd0, errFlag}, 32'd1);

    chk("R10 no missing commits", 32'(expQ.size()), 32'd0);

    // Final state sweep
    for (int i = 0; i < 32; i++) begin
      dbgRegSel = 5'(i); #1;
      chk($sformatf("R3 R5 R8 R9 R10 final reg%0d", i), dbgRegData, refReg[i]);
    end
    for (int i = 0; i < WORDS; i++) begin
      dbgMemSel = 6'(i); #1;
      chk($sformatf("R6 R9 final mem%0d", i), dbgMemData, refMem[i]);
    end
    finish();
  end
endmodule